// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block serialises bytes onto a data line under a shift clock, for a master or a slave role. Software writes a byte into a holding buffer, and the block moves it into a shift register as soon as transmission is enabled and the shifter is free. While one byte shifts out, the next byte can wait in the buffer. When the current frame ends, that waiting byte goes straight into the shifter, so the line carries a continuous stream with no gap between bytes.

In the internal-clock role, the block makes its own shift clock from the system clock with a divider. Each half period lasts a programmable number of system cycles. The shift clock rests high and runs only while a frame is in flight. In the external-clock role, the block follows a shift clock from a remote master. That clock is resynchronised into the local domain, and the block's own clock output stays high.

One latched interrupt request reports one of two selectable events:
- the buffer has become free, or
- the stream has finished.

A one-cycle DMA request accompanies every buffer-free event. The finished event is not permitted together with the external clock, so that combination never raises a request.

Top module: `sync_serial_tx`

## Requirements
- R1: After reset, sclk_o=1, txd_o=1, buf_empty_o=1, busy_o=0, irq_o=0 and dma_req_o=0.
- R2: A tx_wr_i pulse stores tx_data_i and drives buf_empty_o low on the next cycle. buf_empty_o returns high in the cycle after the byte moves into the shift register.
- R3: Internal clock with half period N = div_half_i (0 is treated as 1). At the load edge, sclk_o falls and txd_o shows bit 0. sclk_o then rises N cycles later and falls again N cycles after that, presenting the next bit. Bits go out least significant first: bit k appears 2kN cycles after load. The frame ends 16N cycles after load.
- R4: If the buffer holds a byte when a frame ends and tx_en_i=1, the next byte loads at that same edge, with no idle half period.
- R5: busy_o is high while the buffer holds data or a frame is shifting. It goes low only at a frame end with no reload.
- R6: With irq_fin_sel_i=0, irq_o sets one cycle after each load into the shift register, and one cycle after tx_en_i rises while the buffer is empty. dma_req_o pulses high for one cycle at the same time.
- R7: With irq_fin_sel_i=1 and the internal clock, irq_o sets one cycle after a frame end with no reload. It also sets one cycle after tx_en_i falls.
- R8: With irq_fin_sel_i=1 and clk_ext_sel_i=1, irq_o never sets.
- R9: External clock (clk_ext_sel_i=1): sclk_i passes through a two-stage synchroniser. txd_o shows bit 0 at load and advances on each later falling edge of sclk_i, and the frame ends at the eighth rising edge. sclk_o stays high.
- R10: An irq_ack_i or irq_clr_i pulse clears irq_o on the next cycle. A new set in the same cycle wins over the clear.
- R11: While tx_en_i=0, no byte is loaded: a written byte stays in the buffer, and buf_empty_o stays 0.
- R12: A write in the same cycle as a load keeps the new byte: buf_empty_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | DATA_W | Byte to place in the buffer |
| tx_wr_i | input | 1 | Buffer write strobe |
| tx_en_i | input | 1 | Transmit enable level |
| clk_ext_sel_i | input | 1 | 1 selects the external shift clock |
| irq_fin_sel_i | input | 1 | Interrupt event: 0 buffer free, 1 stream finished |
| div_half_i | input | DIV_W | Half period of the internal shift clock, in system cycles |
| sclk_i | input | 1 | External shift clock |
| irq_ack_i | input | 1 | Vector-read acknowledge pulse, clears the request |
| irq_clr_i | input | 1 | Software clear of the request |
| sclk_o | output | 1 | Generated shift clock, resting high |
| txd_o | output | 1 | Serial data |
| buf_empty_o | output | 1 | Buffer holds no byte |
| busy_o | output | 1 | Transmission status |
| irq_o | output | 1 | Latched transmit interrupt request |
| dma_req_o | output | 1 | One-cycle DMA request per buffer-free event |

## Verification
Two pairs of events can land on the same edge.

The first pair is a buffer write and a load into the shifter. The bench provokes it in two ways: it writes a second byte in the cycle right after the first, and it raises the enable in the same cycle as a write while an older byte waits. The outcome is judged on buf_empty_o, which must stay low, and on the bytes that later appear on txd_o.

The second pair is an interrupt clear and a new interrupt set. The bench holds the acknowledge high through back-to-back traffic, and the cycle-level reference model expects irq_o to be set at each load regardless of the acknowledge.

// File: rtl/sst_pkg.sv
package sst_pkg;
   typedef enum logic {
      SRC_EMPTY = 1'b0,
      SRC_DONE  = 1'b1
   } sst_src_e;

   typedef struct packed {
      logic rise;
      logic fall;
   } sst_edges_t;
endpackage

// File: rtl/sst_edge_sync.sv
module sst_edge_sync
   import sst_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   output sst_edges_t ev_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sst_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         last_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   always_comb begin
      ev_o.rise = chain_q[STAGES-1] & ~last_q;
      ev_o.fall = ~chain_q[STAGES-1] & last_q;
   end
endmodule

// File: rtl/sst_baud.sv
module sst_baud
   import sst_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             restart_i,
   input  logic [DIV_W-1:0] half_i,
   output sst_edges_t       ev_o
);
   if (DIV_W < 1) begin : g_bad_div
      $error("sst_baud: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] cnt_q;
   logic             high_q;   // 1: high half running, next tick is a falling edge
   logic [DIV_W-1:0] half_eff;
   logic             tick;

   assign half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
   assign tick     = run_i && (cnt_q == half_eff - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         high_q <= 1'b0;
      end else if (restart_i || !run_i) begin
         cnt_q  <= '0;
         high_q <= 1'b0;
      end else if (tick) begin
         cnt_q  <= '0;
         high_q <= ~high_q;
      end else begin
         cnt_q  <= cnt_q + DIV_W'(1);
      end
   end

   always_comb begin
      ev_o.rise = tick & ~high_q;
      ev_o.fall = tick & high_q;
   end
endmodule

// File: rtl/sst_buf_shift.sv
module sst_buf_shift
   import sst_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              en_i,
   input  logic              ext_i,
   input  sst_edges_t        ev_i,
   output logic              load_o,
   output logic              done_o,
   output logic              active_o,
   output logic              empty_o,
   output logic              txd_o,
   output logic              sclk_o
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_INT = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] LAST_EXT = CNT_W'(DATA_W - 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("sst_buf_shift: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] buf_q, sr_q;
   logic              empty_q, active_q, txd_q, sclk_q;
   logic [CNT_W-1:0]  bitcnt_q;
   logic              first_bit, shift_bit;
   logic [DATA_W-1:0] load_rest, shift_rest;
   logic              frame_end, start_idle, reload;

   if (LSB_FIRST) begin : g_lsb
      assign first_bit  = buf_q[0];
      assign load_rest  = buf_q >> 1;
      assign shift_bit  = sr_q[0];
      assign shift_rest = sr_q >> 1;
   end else begin : g_msb
      assign first_bit  = buf_q[DATA_W-1];
      assign load_rest  = buf_q << 1;
      assign shift_bit  = sr_q[DATA_W-1];
      assign shift_rest = sr_q << 1;
   end

   always_comb begin
      frame_end  = active_q && (ext_i ? (ev_i.rise && bitcnt_q == LAST_EXT)
                                      : (ev_i.fall && bitcnt_q == LAST_INT));
      start_idle = !active_q && !empty_q && en_i;
      reload     = frame_end && !empty_q && en_i;
      load_o     = start_idle || reload;
      done_o     = frame_end && !reload;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q   <= '0;
         empty_q <= 1'b1;
      end else if (wr_i) begin
         buf_q   <= data_i;
         empty_q <= 1'b0;
      end else if (load_o) begin
         empty_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q     <= '0;
         active_q <= 1'b0;
         bitcnt_q <= '0;
         txd_q    <= 1'b1;
         sclk_q   <= 1'b1;
      end else if (load_o) begin
         sr_q     <= load_rest;
         active_q <= 1'b1;
         bitcnt_q <= '0;
         txd_q    <= first_bit;
         sclk_q   <= ext_i;        // internal role starts with a low half
      end else if (done_o) begin
         active_q <= 1'b0;
         sclk_q   <= 1'b1;
      end else if (active_q) begin
         if (ev_i.rise) begin
            bitcnt_q <= bitcnt_q + CNT_W'(1);
            sclk_q   <= 1'b1;
         end else if (ev_i.fall && bitcnt_q != '0) begin
            txd_q    <= shift_bit;
            sr_q     <= shift_rest;
            sclk_q   <= ext_i;     // only the internal role drives the pin low
         end
      end
   end

   assign active_o = active_q;
   assign empty_o  = empty_q;
   assign txd_o    = txd_q;
   assign sclk_o   = sclk_q;

   // R2
   buf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> !empty_q);
   // R11
   no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !active_q) |=> !active_q);
   // R9
   ext_sclk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_i && sclk_q) |=> sclk_q);
endmodule

// File: rtl/sst_req.sv
module sst_req
   import sst_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en_i,
   input  logic     empty_i,
   input  logic     load_i,
   input  logic     done_i,
   input  logic     ext_i,
   input  sst_src_e src_i,
   input  logic     ack_i,
   input  logic     clr_i,
   output logic     irq_o,
   output logic     dma_o
);
   logic en_q, irq_q, dma_q;
   logic empty_ev, fin_ev, set;

   always_comb begin
      empty_ev = load_i || (en_i && !en_q && empty_i);
      fin_ev   = (done_i && !ext_i) || (en_q && !en_i);
      set      = (src_i == SRC_DONE) ? (fin_ev && !ext_i) : empty_ev;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         irq_q <= 1'b0;
         dma_q <= 1'b0;
      end else begin
         en_q  <= en_i;
         dma_q <= empty_ev && (src_i == SRC_EMPTY);
         if (set)                irq_q <= 1'b1;
         else if (ack_i || clr_i) irq_q <= 1'b0;
      end
   end

   assign irq_o = irq_q;
   assign dma_o = dma_q;

   // R6
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> irq_q);
   // R10
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ack_i || clr_i) && !set) |=> !irq_q);
endmodule

// File: rtl/sync_serial_tx.sv
module sync_serial_tx
   import sst_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic              tx_wr_i,
   input  logic              tx_en_i,
   input  logic              clk_ext_sel_i,
   input  logic              irq_fin_sel_i,
   input  logic [DIV_W-1:0]  div_half_i,
   input  logic              sclk_i,
   input  logic              irq_ack_i,
   input  logic              irq_clr_i,
   output logic              sclk_o,
   output logic              txd_o,
   output logic              buf_empty_o,
   output logic              busy_o,
   output logic              irq_o,
   output logic              dma_req_o
);
   sst_edges_t int_ev, ext_ev, sel_ev;
   logic       load, done, active;
   sst_src_e   src;

   assign src = sst_src_e'(irq_fin_sel_i);

   sst_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(sclk_i), .ev_o(ext_ev)
   );

   sst_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .run_i(active && !clk_ext_sel_i),
      .restart_i(load), .half_i(div_half_i), .ev_o(int_ev)
   );

   assign sel_ev = clk_ext_sel_i ? ext_ev : int_ev;

   sst_buf_shift #(.DATA_W(DATA_W), .LSB_FIRST(LSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .wr_i(tx_wr_i), .data_i(tx_data_i),
      .en_i(tx_en_i), .ext_i(clk_ext_sel_i), .ev_i(sel_ev),
      .load_o(load), .done_o(done), .active_o(active),
      .empty_o(buf_empty_o), .txd_o(txd_o), .sclk_o(sclk_o)
   );

   sst_req u_req (
      .clk(clk), .rst_n(rst_n), .en_i(tx_en_i), .empty_i(buf_empty_o),
      .load_i(load), .done_i(done), .ext_i(clk_ext_sel_i), .src_i(src),
      .ack_i(irq_ack_i), .clr_i(irq_clr_i), .irq_o(irq_o), .dma_o(dma_req_o)
   );

   assign busy_o = active || !buf_empty_o;

   // R8
   no_done_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_ext_sel_i && irq_fin_sel_i && !irq_o) |=> !irq_o);
endmodule

// File: tb/sim_sync_serial_tx.sv
module sim_sync_serial_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_wr = 1'b0, tx_en = 1'b0, ext_sel = 1'b0, fin_sel = 1'b0;
   logic [7:0] div_half = 8'd2;
   logic       sclk_in = 1'b1, ack = 1'b0, clr = 1'b0;
   logic       sclk_o, txd_o, buf_empty_o, busy_o, irq_o, dma_req_o;

   int checks = 0, errors = 0, cyc = 0;

   sync_serial_tx u0 (
      .clk(clk), .rst_n(rst_n), .tx_data_i(tx_data), .tx_wr_i(tx_wr),
      .tx_en_i(tx_en), .clk_ext_sel_i(ext_sel), .irq_fin_sel_i(fin_sel),
      .div_half_i(div_half), .sclk_i(sclk_in), .irq_ack_i(ack), .irq_clr_i(clr),
      .sclk_o(sclk_o), .txd_o(txd_o), .buf_empty_o(buf_empty_o),
      .busy_o(busy_o), .irq_o(irq_o), .dma_req_o(dma_req_o)
   );

   always #10 clk = ~clk;

   // behavioural reference model
   int m_buf, m_sh, m_t, m_bits;
   bit m_empty, m_act, m_txd, m_sclk, m_irq, m_dma, m_en;
   bit h1, h2, h3;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_buf = 0; m_sh = 0; m_t = 0; m_bits = 0;
         m_empty = 1; m_act = 0; m_txd = 1; m_sclk = 1;
         m_irq = 0; m_dma = 0; m_en = 0; h1 = 1; h2 = 1; h3 = 1;
      end else begin
         bit o_empty, o_act, endf, ld, dn, be, fe, st, er, ef;
         int n, k;
         o_empty = m_empty; o_act = m_act; endf = 0;
         n  = (div_half == 0) ? 1 : int'(div_half);
         er = h2 && !h3; ef = !h2 && h3;
         if (m_act) begin
            if (!ext_sel) begin
               m_t++;
               if (m_t % n == 0) begin
                  k = m_t / n;
                  if (k % 2 == 1) begin m_bits = (k + 1) / 2; m_sclk = 1; end
                  else if (k == 16) endf = 1;
                  else begin m_txd = (m_sh >> (k / 2)) & 1; m_sclk = 0; end
               end
            end else begin
               if (er) begin m_bits++; if (m_bits == 8) endf = 1; end
               else if (ef && m_bits >= 1 && m_bits < 8) m_txd = (m_sh >> m_bits) & 1;
            end
         end
         ld = (!o_act && !o_empty && tx_en) || (endf && !o_empty && tx_en);
         dn = endf && !ld;
         if (dn) begin m_act = 0; m_sclk = 1; end
         if (ld) begin
            m_sh = m_buf; m_act = 1; m_t = 0; m_bits = 0;
            m_txd = m_buf & 1; m_sclk = ext_sel;
         end
         if (tx_wr) begin m_buf = tx_data; m_empty = 0; end
         else if (ld) m_empty = 1;
         be = ld || (tx_en && !m_en && o_empty);
         fe = (dn && !ext_sel) || (m_en && !tx_en);
         st = fin_sel ? (fe && !ext_sel) : be;
         if (st) m_irq = 1; else if (ack || clr) m_irq = 0;
         m_dma = be && !fin_sel;
         m_en = tx_en;
         h3 = h2; h2 = h1; h1 = sclk_in;
      end
   end

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   always @(negedge clk) if (rst_n) begin
      chk("R3 txd", txd_o, m_txd);
      chk("R3 sclk", sclk_o, m_sclk);
      chk("R2 buf_empty", buf_empty_o, m_empty);
      chk("R5 busy", busy_o, m_act || !m_empty);
      chk(fin_sel ? (ext_sel ? "R8 irq" : "R7 irq") : "R6 irq", irq_o, m_irq);
      chk("R6 dma", dma_req_o, m_dma);
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [7:0] d);
      tx_data = d; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
   endtask

   task automatic pulse(ref logic s);
      s = 1'b1; tick(1); s = 1'b0;
   endtask

   task automatic ext_frame(int halfp);
      for (int i = 0; i < 8; i++) begin
         sclk_in = 1'b0; tick(halfp); chk("R9 sclk_o high", sclk_o, 1'b1);
         sclk_in = 1'b1; tick(halfp); chk("R9 sclk_o high", sclk_o, 1'b1);
      end
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 sclk", sclk_o, 1'b1);
      chk("R1 txd", txd_o, 1'b1);
      chk("R1 buf_empty", buf_empty_o, 1'b1);
      chk("R1 busy", busy_o, 1'b0);
      chk("R1 irq", irq_o, 1'b0);
      chk("R1 dma", dma_req_o, 1'b0);

      // buffer-free source, internal clock N=2
      tx_en = 1'b1; tick(3);
      chk("R6 irq on enable", irq_o, 1'b1);
      pulse(ack); tick(1);
      chk("R10 ack clears", irq_o, 1'b0);
      wr(8'hA5); wr(8'h3C);      // second write lands on the load edge
      chk("R12 write on load", buf_empty_o, 1'b0);
      for (int i = 0; i < 60; i++) begin
         tick(1); chk("R4 stream busy", busy_o, 1'b1);
      end
      tick(20);

      // acknowledge held through back-to-back loads: set wins (R10)
      ack = 1'b1; wr(8'h11); wr(8'h22); tick(80); ack = 1'b0;

      // finished source, N=3
      pulse(clr); fin_sel = 1'b1; div_half = 8'd3;
      wr(8'h96); tick(60);
      chk("R7 irq at finish", irq_o, 1'b1);
      pulse(clr); tick(1);
      chk("R10 clr clears", irq_o, 1'b0);
      tx_en = 1'b0; tick(2);
      chk("R7 irq on disable", irq_o, 1'b1);
      pulse(clr);

      // disabled: no load (R11)
      wr(8'h5A); tick(40);
      chk("R11 byte held", buf_empty_o, 1'b0);
      chk("R11 busy held", busy_o, 1'b1);
      // enable and write on the same edge (R12)
      tx_en = 1'b1; tx_data = 8'hC3; tx_wr = 1'b1; tick(1); tx_wr = 1'b0; tick(1);
      chk("R12 enable with write", buf_empty_o, 1'b0);
      tick(150);

      // N=1 stream
      pulse(clr); fin_sel = 1'b0; div_half = 8'd1;
      wr(8'h81); wr(8'h7E); tick(16); wr(8'hF0); tick(60);

      // external clock, buffer-free source (R9)
      ext_sel = 1'b1; tick(4);
      wr(8'h69); tick(3);
      ext_frame(4);
      wr(8'hB4); tick(3);
      ext_frame(4);
      tick(10);

      // external clock with finished source is suppressed (R8)
      fin_sel = 1'b1; pulse(clr); tick(2);
      wr(8'h0F); tick(3);
      ext_frame(3);
      tick(10);
      chk("R8 no irq", irq_o, 1'b0);
      tx_en = 1'b0; tick(3);
      chk("R8 no irq on disable", irq_o, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule